// File: doc/BRIEF.md
# System Bus Access Engine

This block lets a debugger perform single 32-bit memory reads and writes on a system bus without involving any processor. The debugger reaches it through word-wide register reads and writes on a small debug register port. Four registers are decoded: a module control word whose bit 0 is the active flag, an access control and status word, an address word and a data word. Bus accesses are never requested explicitly. They are launched as a side effect of register writes. A read starts when the address word is written while read-on-address is enabled. A write starts when the data word is written, using the address that is held at that moment.

The unit is dormant after reset. It reads as all zeros and ignores every access until the active flag has been written to 1 and a fixed activation latency has elapsed. The debugger then polls the busy flag to learn when an access has completed. Two kinds of fault are reported in sticky flags: an access attempted while the unit is busy, and a failed or unsupported bus access. While either flag is set, no new access is launched. Both flags are cleared by writing ones to them.

Top module: `sba_engine`

## Requirements
- R1: After reset every register reads 0. Writing 1 to bit 0 of the control word (register 0x10) leaves that word reading 0 for ACT_LAT clock cycles, after which it reads 1. The status word (0x38) reads 0 for as long as bit 0 of 0x10 reads 0.
- R2: While the unit is inactive, writes to 0x38, 0x39 and 0x3C have no effect, and bus_req stays low.
- R3: Once active and idle, the status word reads 0x2004_0404. That value carries a version field of 1 in bits 31:29, an access-size field of 2 (32-bit) in bits 19:17, a bus address width of 32 in bits 11:5, and the 32-bit capability flag in bit 2.
- R4: When read-on-address (status bit 20) is set, writing the address word (0x39) raises bus_req with bus_we low and bus_addr equal to the written value at the next clock edge. While the access is outstanding, status bit 21 (busy) reads 1. When read-on-address is clear, writing the address word starts no access.
- R5: Writing the data word (0x3C) while idle raises bus_req with bus_we high, bus_addr equal to the stored address and bus_wdata equal to the written data.
- R6: The cycle after bus_rsp is seen with bus_req high, bus_req and busy are low. For an error-free read, the data word then holds bus_rdata.
- R7: A write to 0x39 or 0x3C, or a read of 0x3C, while busy is ignored and sets the sticky busy-error flag (status bit 22). Writing 1 to bit 22 clears that flag.
- R8: A response with bus_err set makes the error field (status bits 14:12) read 7. Writing ones to those bits clears the field. While the error field is nonzero or busy-error is set, no access is launched.
- R9: A launch attempted while the access-size field is not 2 starts no bus access and sets the error field to 4.
- R10: Writing 0 to bit 0 of 0x10 deactivates the unit at once. Its status reads 0, and after reactivation the address and data words read 0.
- R11: While bus_req is high and no response has arrived, bus_req, bus_we, bus_addr and bus_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 for a register write, 0 for a read |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the register selected by reg_addr (combinational) |
| bus_req | output | 1 | Bus access outstanding, held until the response |
| bus_we | output | 1 | 1 for a bus write |
| bus_addr | output | BUS_AW | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rsp | input | 1 | Bus response strobe |
| bus_err | input | 1 | Bus response carries an error |
| bus_rdata | input | 32 | Bus read data, valid with bus_rsp |

## Verification
The hardest state to reach is a register access that collides with an access still in flight on the bus. The bench reaches it with a responder model whose response latency can be adjusted. It sets a long latency so that further address writes and data reads land while busy is high. It then checks that the address on the bus does not move, that busy-error sticks, and that the fault blocks later launches until it is cleared. The same responder returns error responses for any address with bit 31 set, which drives the error field without needing a faulty bus. The main sweep repeats reads and writes over a grid of addresses and response latencies.

// File: rtl/sba_engine.sv
module sba_engine #(
  parameter int ADDR_W  = 7,
  parameter int BUS_AW  = 32,
  parameter int ACT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_rsp,
  input  logic              bus_err,
  input  logic [31:0]       bus_rdata
);
  localparam int CW = $clog2(ACT_LAT + 1);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(7'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(7'h38);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(7'h39);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(7'h3C);
  localparam logic [2:0] SZ32 = 3'd2;

  logic          active, pend;
  logic [CW-1:0] act_cnt;
  logic          busy, busyerr, roa, we_q;
  logic [2:0]    access, err;
  logic [BUS_AW-1:0] addr_q;
  logic [31:0]   data_q;

  wire wr       = reg_req & reg_we;
  wire deact    = wr & (reg_addr == A_CTL) & ~reg_wdata[0];
  wire arm      = wr & (reg_addr == A_CTL) & reg_wdata[0] & ~active & ~pend;
  wire acc_addr = active & wr & (reg_addr == A_ADDR);
  wire acc_wdat = active & wr & (reg_addr == A_DATA);
  wire acc_rdat = active & reg_req & ~reg_we & (reg_addr == A_DATA);
  wire stat_wr  = active & wr & (reg_addr == A_STAT);
  wire collide  = busy & (acc_addr | acc_wdat | acc_rdat);
  wire blocked  = busyerr | (err != 3'd0);
  wire go_rd    = acc_addr & ~busy & roa & ~blocked;
  wire go_wr    = acc_wdat & ~busy & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pend    <= 1'b0;
      act_cnt <= '0;
      busy    <= 1'b0;
      busyerr <= 1'b0;
      roa     <= 1'b0;
      we_q    <= 1'b0;
      access  <= SZ32;
      err     <= 3'd0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (deact) begin
      active  <= 1'b0;
      pend    <= 1'b0;
      act_cnt <= '0;
      busy    <= 1'b0;
      busyerr <= 1'b0;
      roa     <= 1'b0;
      we_q    <= 1'b0;
      access  <= SZ32;
      err     <= 3'd0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (arm) begin
        pend    <= 1'b1;
        act_cnt <= '0;
      end else if (pend) begin
        if (act_cnt == CW'(ACT_LAT - 1)) begin
          active <= 1'b1;
          pend   <= 1'b0;
        end else begin
          act_cnt <= act_cnt + 1'b1;
        end
      end
      if (stat_wr) begin
        roa    <= reg_wdata[20];
        access <= reg_wdata[19:17];
        if (reg_wdata[22]) busyerr <= 1'b0;
        err <= err & ~reg_wdata[14:12];
      end
      if (collide) busyerr <= 1'b1;
      if (acc_addr && !busy) addr_q <= reg_wdata[BUS_AW-1:0];
      if (acc_wdat && !busy) data_q <= reg_wdata;
      if (go_rd || go_wr) begin
        if (access != SZ32) begin
          err <= 3'd4;
        end else begin
          busy <= 1'b1;
          we_q <= go_wr;
        end
      end
      if (busy && bus_rsp) begin
        busy <= 1'b0;
        if (bus_err) err <= 3'd7;
        else if (!we_q) data_q <= bus_rdata;
      end
    end
  end

  wire [31:0] stat_word = {3'd1, 6'd0, busyerr, busy, roa, access, 1'b0, 1'b0,
                           err, 7'(BUS_AW), 5'b00100};

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == A_CTL)                 reg_rdata = {31'd0, active};
    else if (active && reg_addr == A_STAT) reg_rdata = stat_word;
    else if (active && reg_addr == A_ADDR) reg_rdata = 32'(addr_q);
    else if (active && reg_addr == A_DATA) reg_rdata = data_q;
  end

  assign bus_req   = busy;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
endmodule

// File: rtl/sba_engine_chk.sv
module sba_engine_chk #(
  parameter int ADDR_W = 7,
  parameter int BUS_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rsp,
  input logic              bus_err,
  input logic              busyerr,
  input logic [2:0]        err
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(7'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(7'h38);

  wire kill  = reg_req & reg_we & (reg_addr == A_CTL) & ~reg_wdata[0];
  wire be_wc = reg_req & reg_we & (reg_addr == A_STAT) & reg_wdata[22];

  p_idle_when_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT && reg_rdata == 32'd0) |-> !bus_req);

  p_busy_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT && bus_req) |-> reg_rdata[21]);

  p_rsp_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rsp) |=> !bus_req);

  p_busyerr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busyerr && !be_wc && !kill) |=> busyerr);

  p_err_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rsp && bus_err && !reg_req) |=> err == 3'd7);

  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((busyerr || err != 3'd0) && !bus_req) |=> !bus_req);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rsp && !kill) |=>
      (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind sba_engine sba_engine_chk #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rsp(bus_rsp), .bus_err(bus_err),
  .busyerr(busyerr), .err(err)
);

// File: tb/test_sba_engine.sv
module test_sba_engine;
  localparam int ACT_LAT = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 1'b0, reg_we = 1'b0;
  logic [6:0] reg_addr = 7'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic bus_req, bus_we, bus_rsp = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 32'd0;
  int checks = 0, fails = 0, rsp_dly = 1;
  logic [31:0] seen_addr = 32'd0, seen_data = 32'd0;

  always #10 clk = ~clk;

  sba_engine #(.ADDR_W(7), .BUS_AW(32), .ACT_LAT(ACT_LAT)) i_sba_engine (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rsp(bus_rsp), .bus_err(bus_err),
    .bus_rdata(bus_rdata));

  function automatic logic [31:0] model(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] stat(input logic be, b, ro, input logic [2:0] acc, e);
    return (32'd1 << 29) | (32'(be) << 22) | (32'(b) << 21) | (32'(ro) << 20) |
           (32'(acc) << 17) | (32'(e) << 12) | (32'd32 << 5) | 32'd4;
  endfunction

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (bus_rsp) begin
        bus_rsp = 1'b0; bus_err = 1'b0; cnt = 0;
      end else if (bus_req) begin
        cnt++;
        if (cnt >= rsp_dly) begin
          bus_rsp = 1'b1;
          bus_err = bus_addr[31];
          bus_rdata = model(bus_addr);
          if (bus_we) begin seen_addr = bus_addr; seen_data = bus_wdata; end
        end
      end else cnt = 0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic peek(input logic [6:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (bus_req && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic activate();
    wr(7'h10, 32'd1);
    repeat (ACT_LAT) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(7'h10, v); chk("R1 ctl reset", v, 0);
    peek(7'h38, v); chk("R1 stat reset", v, 0);
    peek(7'h39, v); chk("R1 addr reset", v, 0);
    peek(7'h3C, v); chk("R1 data reset", v, 0);

    wr(7'h38, 32'h0014_0000);
    wr(7'h39, 32'h0000_0040);
    chk("R2 no bus while inactive", 32'(bus_req), 0);
    wr(7'h3C, 32'h1234_5678);
    chk("R2 no bus on data write", 32'(bus_req), 0);

    wr(7'h10, 32'd1);
    for (int k = 0; k <= ACT_LAT; k++) begin
      peek(7'h10, v); chk("R1 ctl activation", v, (k >= ACT_LAT) ? 1 : 0);
      peek(7'h38, v); chk("R1 stat dark", v == 0 ? 1 : 0, (k >= ACT_LAT) ? 0 : 1);
      if (k < ACT_LAT) @(negedge clk);
    end
    peek(7'h38, v); chk("R3 stat fields", v, 32'h2004_0404);
    chk("R3 stat fn", v, stat(0, 0, 0, 2, 0));
    peek(7'h39, v); chk("R2 addr untouched", v, 0);
    peek(7'h3C, v); chk("R2 data untouched", v, 0);

    for (int dly = 1; dly <= 4; dly++) begin
      rsp_dly = dly;
      for (int i = 0; i < 8; i++) begin
        a = 32'h100 + 32'(i) * 32'h44 + 32'(dly) * 32'h1000;
        wr(7'h38, stat(0, 0, 1, 2, 0));
        wr(7'h39, a);
        chk("R4 read req", 32'(bus_req), 1);
        chk("R4 read we", 32'(bus_we), 0);
        chk("R4 read addr", bus_addr, a);
        peek(7'h38, v); chk("R4 busy bit", 32'(v[21]), 1);
        wait_idle();
        chk("R6 busy clear", 32'(bus_req), 0);
        peek(7'h3C, v); chk("R6 read data", v, model(a));
        d = ~model(a);
        wr(7'h38, stat(0, 0, 0, 2, 0));
        wr(7'h39, a + 4);
        chk("R4 no read without roa", 32'(bus_req), 0);
        wr(7'h3C, d);
        chk("R5 write req", 32'(bus_req), 1);
        chk("R5 write we", 32'(bus_we), 1);
        chk("R5 write addr", bus_addr, a + 4);
        chk("R5 write data", bus_wdata, d);
        wait_idle();
        chk("R5 bus saw addr", seen_addr, a + 4);
        chk("R5 bus saw data", seen_data, d);
        peek(7'h38, v); chk("R6 stat idle", v, stat(0, 0, 0, 2, 0));
      end
    end

    rsp_dly = 20;
    wr(7'h38, stat(0, 0, 1, 2, 0));
    wr(7'h39, 32'h0000_0A00);
    wr(7'h39, 32'h0000_0B00);
    chk("R7 addr kept", bus_addr, 32'h0000_0A00);
    chk("R11 req held", 32'(bus_req), 1);
    peek(7'h38, v); chk("R7 busyerr set", 32'(v[22]), 1);
    wait_idle();
    peek(7'h39, v); chk("R7 addr reg unchanged", v, 32'h0000_0A00);
    peek(7'h3C, v); chk("R7 read done", v, model(32'h0000_0A00));
    rsp_dly = 1;
    wr(7'h3C, 32'hCAFE_0001);
    chk("R8 blocked by busyerr", 32'(bus_req), 0);
    wr(7'h38, stat(1, 0, 1, 2, 0));
    peek(7'h38, v); chk("R7 busyerr w1c", v, stat(0, 0, 1, 2, 0));

    rsp_dly = 20;
    wr(7'h39, 32'h0000_0C00);
    rd(7'h3C, v);
    peek(7'h38, v); chk("R7 data read while busy", 32'(v[22]), 1);
    wait_idle();
    wr(7'h38, stat(1, 0, 1, 2, 0));
    rsp_dly = 1;

    wr(7'h39, 32'h8000_0010);
    wait_idle();
    peek(7'h38, v); chk("R8 error field", v, stat(0, 0, 1, 2, 7));
    wr(7'h39, 32'h0000_0020);
    chk("R8 blocked by error", 32'(bus_req), 0);
    wr(7'h38, stat(0, 0, 1, 2, 7));
    peek(7'h38, v); chk("R8 error w1c", v, stat(0, 0, 1, 2, 0));

    wr(7'h38, stat(0, 0, 1, 0, 0));
    wr(7'h39, 32'h0000_0030);
    chk("R9 no bus on bad size", 32'(bus_req), 0);
    peek(7'h38, v); chk("R9 size error", v, stat(0, 0, 1, 0, 4));
    wr(7'h38, stat(0, 0, 0, 2, 7));

    wr(7'h3C, 32'h5555_AAAA);
    wait_idle();
    wr(7'h10, 32'd0);
    peek(7'h10, v); chk("R10 ctl off", v, 0);
    peek(7'h38, v); chk("R10 stat dark", v, 0);
    activate();
    peek(7'h39, v); chk("R10 addr cleared", v, 0);
    peek(7'h3C, v); chk("R10 data cleared", v, 0);
    peek(7'h38, v); chk("R10 stat fresh", v, 32'h2004_0404);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule